// File: doc/BRIEF.md
# Coherent Clock Freeze Controller

This block drives the clocks of a design under test that runs on an accelerator while its stimulus comes from a much slower host testbench. Each clock is derived from one fast free-running reference. A high count and a low count, set separately for each clock, fix that clock's period and duty cycle. Every transactor reports two levels: one says it holds stimulus for the next stretch of cycles, and the other says its buffer has run dry. Edges are produced only while the whole group of transactors is supplied. A single starving transactor stops every clock at once, so the hardware never runs ahead of the host.

A sequencer state machine has three states. `G_FROZEN` is the reset state. From `G_FROZEN` the transition *start* enters `G_RUN` when every ready bit is set and no empty bit is set. From `G_RUN` the transition *stop* enters `G_DRAIN` when any empty bit is set, and it records which transactors were empty. From `G_DRAIN` the transition *settle* returns to `G_FROZEN` once every clock generator sits at a phase boundary.

Each clock generator is a state machine with five states: `CG_OFF`, `CG_PARK_LO`, `CG_HIGH`, `CG_LOW` and `CG_PARK_HI`. A phase always completes before the generator parks, and a parked generator keeps its level. On resume it enters the opposite phase with a full count. A zero count sends a generator to `CG_OFF` from any state, and it holds its output low there. When both counts are non-zero again it leaves `CG_OFF` for `CG_PARK_LO`.

Top module: `clkfrz_ctrl`

## Requirements
- R1: After reset `frozen` is 1, and `clk_out`, `clk_rise` and `stop_cause` are all 0.
- R2: Clocks start only after a cycle in which every `xact_ready` bit is 1 and every `xact_empty` bit is 0. `frozen` drops at the first clock edge that samples this condition.
- R3: While running, clock i is high for exactly `cfg_high[i]` reference cycles and low for exactly `cfg_low[i]` cycles. Clock i's high count is the field at bits i*W up to i*W+W-1, and its low count sits at the same bits of `cfg_low`. `clk_rise[i]` is 1 in the first high cycle only. Clocks released together rise together, one cycle after `frozen` drops.
- R4: Any `xact_empty` bit set while running stops all clocks. Each clock finishes its current phase first, so no high phase is ever shorter than its programmed count. `frozen` rises once every clock is parked.
- R5: While `frozen` is 1, every `clk_out` bit keeps its level and `clk_rise` stays 0.
- R6: `stop_cause` bit j takes the value of `xact_empty` bit j at the edge where a stop begins. The field keeps that value until the next stop. Empty bits seen while frozen do not change it.
- R7: After a resume, a clock parked high spends its next phase low for the full low count. A clock parked low spends its next phase high for the full high count.
- R8: A zero high or low count holds that clock low from the next cycle on, and the other clocks keep toggling.
- R9: Ready from only some transactors leaves the block frozen with all clocks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_ready | input | N_XACT | Per-transactor stimulus-ready level |
| xact_empty | input | N_XACT | Per-transactor buffer-empty level (stop request) |
| cfg_high | input | N_CLK*CNT_W | High-phase counts, clock i at bits [i*CNT_W +: CNT_W] |
| cfg_low | input | N_CLK*CNT_W | Low-phase counts, same layout |
| clk_out | output | N_CLK | Generated clock levels |
| clk_rise | output | N_CLK | One-cycle pulse in the first high cycle of each clock |
| frozen | output | 1 | All clocks parked |
| stop_cause | output | N_XACT | Empty vector captured at the most recent stop |

## Verification
Several properties are checked on every cycle. No rising strobe appears while frozen, and the clock levels stay steady across frozen cycles. A zero count forces its clock low on the next cycle. No high phase ends before its programmed count. The stop-cause field changes only at a stop taken from running. The scenarios are needed to show the rest: the exact start latency, the programmed period and duty cycle, the captured cause for different starving sets, and the full-length phase that follows a resume. They also show that partial readiness and empties arriving while frozen have no effect.

// File: rtl/clkfrz_pkg.sv
package clkfrz_pkg;

    typedef enum logic [1:0] {
        G_FROZEN = 2'd0,
        G_RUN    = 2'd1,
        G_DRAIN  = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        CG_OFF     = 3'd0,
        CG_PARK_LO = 3'd1,
        CG_HIGH    = 3'd2,
        CG_LOW     = 3'd3,
        CG_PARK_HI = 3'd4
    } gen_state_e;

endpackage

// File: rtl/clkfrz_gen.sv
module clkfrz_gen
    import clkfrz_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             clk_lvl,
    output logic             rise,
    output logic             idle
);

    gen_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             disabled;
    logic             hi_done;
    logic             lo_done;

    assign disabled = (hi_len == '0) || (lo_len == '0);
    assign hi_done  = (cnt_q >= hi_len);
    assign lo_done  = (cnt_q >= lo_len);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CG_PARK_LO;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CG_OFF: begin
                if (!disabled) state_d = CG_PARK_LO;
            end
            CG_PARK_LO: begin
                if (disabled) begin
                    state_d = CG_OFF;
                end else if (run) begin
                    state_d = CG_HIGH;
                    cnt_d   = CNT_W'(1);
                end
            end
            CG_HIGH: begin
                if (disabled) begin
                    state_d = CG_OFF;
                end else if (hi_done) begin
                    if (run) begin
                        state_d = CG_LOW;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        state_d = CG_PARK_HI;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            CG_LOW: begin
                if (disabled) begin
                    state_d = CG_OFF;
                end else if (lo_done) begin
                    if (run) begin
                        state_d = CG_HIGH;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        state_d = CG_PARK_LO;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            CG_PARK_HI: begin
                if (disabled) begin
                    state_d = CG_OFF;
                end else if (run) begin
                    state_d = CG_LOW;
                    cnt_d   = CNT_W'(1);
                end
            end
            default: begin
                state_d = CG_OFF;
            end
        endcase
    end

    // outputs
    always_comb begin
        clk_lvl = 1'b0;
        rise    = 1'b0;
        idle    = 1'b0;
        unique case (state_q)
            CG_OFF:     idle = 1'b1;
            CG_PARK_LO: idle = 1'b1;
            CG_HIGH: begin
                clk_lvl = 1'b1;
                rise    = (cnt_q == CNT_W'(1));
            end
            CG_LOW:     clk_lvl = 1'b0;
            CG_PARK_HI: begin
                clk_lvl = 1'b1;
                idle    = 1'b1;
            end
            default:    idle = 1'b1;
        endcase
    end

endmodule

// File: rtl/clkfrz_seq.sv
module clkfrz_seq
    import clkfrz_pkg::*;
#(
    parameter int N_XACT = 3,
    parameter int N_CLK  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_XACT-1:0] xact_ready,
    input  logic [N_XACT-1:0] xact_empty,
    input  logic [N_CLK-1:0]  gen_idle,
    output logic              run,
    output logic              frozen,
    output logic [N_XACT-1:0] stop_cause
);

    seq_state_e        state_q, state_d;
    logic [N_XACT-1:0] cause_q, cause_d;
    logic              all_ready;
    logic              any_empty;
    logic              all_idle;

    assign all_ready = (&xact_ready) && !(|xact_empty);
    assign any_empty = |xact_empty;
    assign all_idle  = &gen_idle;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= G_FROZEN;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // transitions: start, stop, settle
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            G_FROZEN: begin
                if (all_ready) state_d = G_RUN;
            end
            G_RUN: begin
                if (any_empty) begin
                    state_d = G_DRAIN;
                    cause_d = xact_empty;
                end
            end
            G_DRAIN: begin
                if (all_idle) state_d = G_FROZEN;
            end
            default: begin
                state_d = G_FROZEN;
            end
        endcase
    end

    // outputs
    always_comb begin
        run        = 1'b0;
        frozen     = 1'b0;
        stop_cause = cause_q;
        unique case (state_q)
            G_FROZEN: frozen = 1'b1;
            G_RUN:    run    = 1'b1;
            G_DRAIN:  run    = 1'b0;
            default:  frozen = 1'b1;
        endcase
    end

endmodule

// File: rtl/clkfrz_ctrl.sv
module clkfrz_ctrl #(
    parameter int N_XACT = 3,
    parameter int N_CLK  = 2,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_XACT-1:0]       xact_ready,
    input  logic [N_XACT-1:0]       xact_empty,
    input  logic [N_CLK*CNT_W-1:0]  cfg_high,
    input  logic [N_CLK*CNT_W-1:0]  cfg_low,
    output logic [N_CLK-1:0]        clk_out,
    output logic [N_CLK-1:0]        clk_rise,
    output logic                    frozen,
    output logic [N_XACT-1:0]       stop_cause
);

    logic             run;
    logic [N_CLK-1:0] gen_idle;

    clkfrz_seq #(
        .N_XACT(N_XACT),
        .N_CLK (N_CLK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .xact_ready(xact_ready),
        .xact_empty(xact_empty),
        .gen_idle  (gen_idle),
        .run       (run),
        .frozen    (frozen),
        .stop_cause(stop_cause)
    );

    for (genvar i = 0; i < N_CLK; i++) begin : g_gen
        clkfrz_gen #(
            .CNT_W(CNT_W)
        ) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .hi_len (cfg_high[i*CNT_W +: CNT_W]),
            .lo_len (cfg_low[i*CNT_W +: CNT_W]),
            .clk_lvl(clk_out[i]),
            .rise   (clk_rise[i]),
            .idle   (gen_idle[i])
        );
    end

endmodule

// File: rtl/clkfrz_ctrl_chk.sv
module clkfrz_ctrl_chk #(
    parameter int N_XACT = 3,
    parameter int N_CLK  = 2,
    parameter int CNT_W  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_XACT-1:0]      xact_empty,
    input logic [N_CLK*CNT_W-1:0] cfg_high,
    input logic [N_CLK*CNT_W-1:0] cfg_low,
    input logic [N_CLK-1:0]       clk_out,
    input logic [N_CLK-1:0]       clk_rise,
    input logic                   frozen,
    input logic [N_XACT-1:0]      stop_cause
);

    // R5
    no_rise_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> (clk_rise == '0));

    // R5
    hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && $past(frozen)) |-> $stable(clk_out));

    // R6
    cause_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stop_cause) |-> ($past(|xact_empty) && !$past(frozen)));

    for (genvar i = 0; i < N_CLK; i++) begin : g_clk
        logic [CNT_W:0] hrun_q;
        logic           cfg_ok;

        assign cfg_ok = (cfg_high[i*CNT_W +: CNT_W] != '0) &&
                        (cfg_low[i*CNT_W +: CNT_W] != '0);

        always_ff @(posedge clk) begin
            if (!rst_n) hrun_q <= '0;
            else if (clk_out[i]) hrun_q <= (&hrun_q) ? hrun_q : hrun_q + 1'b1;
            else hrun_q <= '0;
        end

        // R8
        zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_ok |=> !clk_out[i]);

        // R4
        full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(clk_out[i]) && cfg_ok) |->
                (hrun_q >= {1'b0, cfg_high[i*CNT_W +: CNT_W]}));
    end

endmodule

bind clkfrz_ctrl clkfrz_ctrl_chk #(
    .N_XACT(N_XACT),
    .N_CLK (N_CLK),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xact_empty(xact_empty),
    .cfg_high  (cfg_high),
    .cfg_low   (cfg_low),
    .clk_out   (clk_out),
    .clk_rise  (clk_rise),
    .frozen    (frozen),
    .stop_cause(stop_cause)
);

// File: tb/clkfrz_ctrl_bench.sv
module clkfrz_ctrl_bench;

    localparam int NX = 3;
    localparam int NC = 2;
    localparam int W  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NX-1:0]   xact_ready = '0;
    logic [NX-1:0]   xact_empty = '0;
    logic [NC*W-1:0] cfg_high = {8'd1, 8'd2};
    logic [NC*W-1:0] cfg_low  = {8'd1, 8'd3};
    logic [NC-1:0]   clk_out;
    logic [NC-1:0]   clk_rise;
    logic            frozen;
    logic [NX-1:0]   stop_cause;

    int checks = 0;
    int errors = 0;
    int viol   = 0;
    int hrun [NC];

    always #5 clk = ~clk;

    clkfrz_ctrl #(.N_XACT(NX), .N_CLK(NC), .CNT_W(W)) u_clkfrz_ctrl (
        .clk(clk), .rst_n(rst_n), .xact_ready(xact_ready), .xact_empty(xact_empty),
        .cfg_high(cfg_high), .cfg_low(cfg_low), .clk_out(clk_out),
        .clk_rise(clk_rise), .frozen(frozen), .stop_cause(stop_cause)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // background monitor of high-phase widths (R4)
    initial begin
        for (int i = 0; i < NC; i++) hrun[i] = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int i = 0; i < NC; i++) begin
                    if (clk_out[i]) hrun[i]++;
                    else begin
                        if (hrun[i] > 0 && cfg_high[i*W +: W] != 0 && cfg_low[i*W +: W] != 0
                            && hrun[i] < int'(cfg_high[i*W +: W])) viol++;
                        hrun[i] = 0;
                    end
                end
            end
        end
    end

    task automatic measure(input int idx, input int exp_h, input int exp_l, input string tag);
        int h = 0;
        int l = 0;
        int g = 0;
        while (clk_out[idx] !== 1'b0 && g < 100) begin @(negedge clk); g++; end
        while (clk_out[idx] !== 1'b1 && g < 100) begin @(negedge clk); g++; end
        while (clk_out[idx] === 1'b1 && h < 100) begin @(negedge clk); h++; end
        while (clk_out[idx] === 1'b0 && l < 100) begin @(negedge clk); l++; end
        chk(h == exp_h, {tag, " high width"}, h, exp_h);
        chk(l == exp_l, {tag, " low width"}, l, exp_l);
    endtask

    task automatic wait_frozen(input string tag);
        int g = 0;
        while (!frozen && g < 30) begin @(negedge clk); g++; end
        chk(frozen == 1'b1, tag, int'(frozen), 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk(frozen == 1'b1, "R1 frozen after reset", int'(frozen), 1);
        chk(clk_out == '0 && clk_rise == '0, "R1 clocks low after reset", int'(clk_out), 0);
        chk(stop_cause == '0, "R1 stop cause clear", int'(stop_cause), 0);
    endtask

    task automatic t_partial;
        bit ok = 1'b1;
        xact_ready = 3'b011;
        repeat (8) begin
            @(negedge clk);
            if (!frozen || clk_out != '0) ok = 1'b0;
        end
        // R9
        chk(ok, "R9 partial ready stays frozen", int'(clk_out), 0);
    endtask

    task automatic t_start;
        xact_ready = 3'b111;
        @(negedge clk);
        // R2
        chk(frozen == 1'b0, "R2 frozen drops one edge after ready", int'(frozen), 0);
        @(negedge clk);
        // R3
        chk(clk_out == 2'b11, "R3 clocks rise together", int'(clk_out), 3);
        chk(clk_rise == 2'b11, "R3 rise strobe", int'(clk_rise), 3);
        measure(0, 2, 3, "R3 clk0");
        measure(1, 1, 1, "R3 clk1");
    endtask

    task automatic t_stop_resume;
        bit ok = 1'b1;
        logic [NC-1:0] held;
        logic v;
        int g = 0;
        int n = 0;
        int exp_n;
        xact_empty = 3'b010;
        wait_frozen("R4 freeze after empty");
        // R6
        chk(stop_cause == 3'b010, "R6 cause captured", int'(stop_cause), 2);
        held = clk_out;
        repeat (10) begin
            @(negedge clk);
            if (clk_out != held || clk_rise != '0 || !frozen) ok = 1'b0;
        end
        // R5
        chk(ok, "R5 levels held while frozen", int'(clk_out), int'(held));
        v = clk_out[0];
        xact_empty = '0;
        @(negedge clk);
        chk(frozen == 1'b0, "R2 resume after empty clears", int'(frozen), 0);
        while (clk_out[0] == v && g < 20) begin @(negedge clk); g++; end
        while (clk_out[0] != v && n < 20) begin @(negedge clk); n++; end
        exp_n = v ? 3 : 2;
        // R7
        chk(n == exp_n, "R7 full phase after resume", n, exp_n);
    endtask

    task automatic t_cause;
        xact_empty = 3'b101;
        wait_frozen("R4 freeze on two empties");
        // R6
        chk(stop_cause == 3'b101, "R6 cause two bits", int'(stop_cause), 5);
        xact_empty = 3'b010;
        repeat (5) @(negedge clk);
        chk(stop_cause == 3'b101 && frozen, "R6 empty while frozen ignored", int'(stop_cause), 5);
        xact_empty = '0;
        @(negedge clk);
        chk(frozen == 1'b0, "R2 second resume", int'(frozen), 0);
    endtask

    task automatic t_zero;
        bit ok = 1'b1;
        cfg_high[W +: W] = 8'd0;
        repeat (2) @(negedge clk);
        repeat (20) begin
            @(negedge clk);
            if (clk_out[1] != 1'b0) ok = 1'b0;
        end
        // R8
        chk(ok, "R8 zero count holds clock low", int'(clk_out[1]), 0);
        measure(0, 2, 3, "R8 other clock unaffected");
        cfg_high[W +: W] = 8'd1;
        measure(1, 1, 1, "R8 clock restored");
    endtask

    initial begin
        t_reset;
        t_partial;
        t_start;
        t_stop_resume;
        t_cause;
        t_zero;
        // R4
        chk(viol == 0, "R4 no shortened high phase", viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule